// File: doc/BRIEF.md
# Register-Mapped Serial Peripheral Host

This block is a host-side serial peripheral interface (SPI) master with a 32-bit APB-style register port. Software first clears the enable register. While the block is disabled, software programs the frame width, clock phase and polarity, transfer direction, clock divider and target select. It then sets the enable register and writes words to the data register. Each word waits in a small transmit queue until the shift engine takes it.

The engine sends each word most significant bit first on `mosi` and captures `miso` into a receive queue. Software pops the receive queue by reading the data register. While frames are being shifted, the engine drives the selected active-low target-select line. It releases that line once both the transmit queue and the engine are empty. Queue levels, a status word and a fixed version word can be read at any time. Clearing the enable register aborts the current frame and empties both queues.

Top module: `apb_spi_host`

## Requirements
- R1: After reset, control (0x00) reads 0x007, divider (0x14) reads 2, enable (0x08) reads 0, target select (0x10) reads 0, status (0x28) reads 0x06, version (0x5C) reads 0x00010200, `ss_n` is all ones and `sclk` is low.
- R2: While enable bit 0 is 1, writes to control, frame count (0x04), target select, divider and threshold (0x18) leave those registers unchanged.
- R3: Writing 0 to enable stops the shift engine, releases `ss_n`, and makes both queue levels (TX at 0x20, RX at 0x24) read 0.
- R4: In mode 0 (control bits [9:8] = 0), each queued word is sent as a frame of control[3:0]+1 bits, MSB first. The received bits are stored right-aligned in the RX queue, and each data read (0x60) returns them in order.
- R5: The `sclk` level when idle equals control bit 7. With control bit 6 = 0, both sides sample on the first edge of each bit. With control bit 6 = 1, they sample on the second edge.
- R6: Within a frame, the `sclk` period is the divider value in clock cycles. Divider bit 0 is forced to 0 on write, and a value below 2 behaves as 2.
- R7: `ss_n[n]` is low exactly while the engine is busy and target-select bit n is set.
- R8: In mode 1 (transmit only), frames are shifted but the RX queue level does not change.
- R9: In mode 2 (receive only), one data write starts frame count + 1 frames, with `mosi` held at all ones. The written word is not queued.
- R10: The queues hold 8 words. A data write while the TX queue is full is dropped, and a data read while the RX queue is empty returns 0.
- R11: A threshold write of a value from 0 to 7 is stored. A write of 8 or more leaves the old value, so the queue depth can be probed.
- R12: The status bits are: bit 0 busy, bit 1 TX not full, bit 2 TX empty, bit 3 RX not empty, bit 4 RX full; bits 5 and 6 read 0. Busy stays 1 until the last frame has finished shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Register byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 4 | Active-low target selects |

## Verification
A corrupted bit counter or edge counter in the engine shows up within one frame. The frame width at the target model comes out wrong, and so does the word returned from the RX queue. A corrupted phase register leaves `sclk` away from its idle level once `ss_n` has released, which a per-clock monitor flags in the same cycle. Wrong queue pointers show up as level or data mismatches at the next register read. A missed flush shows up as a nonzero level read straight after disabling.

// File: rtl/apb_spi_host_pkg.sv
package apb_spi_host_pkg;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_CNT  = 8'h04;
  localparam logic [7:0] OFS_EN   = 8'h08;
  localparam logic [7:0] OFS_SSEL = 8'h10;
  localparam logic [7:0] OFS_DIV  = 8'h14;
  localparam logic [7:0] OFS_THR  = 8'h18;
  localparam logic [7:0] OFS_TXL  = 8'h20;
  localparam logic [7:0] OFS_RXL  = 8'h24;
  localparam logic [7:0] OFS_STAT = 8'h28;
  localparam logic [7:0] OFS_MASK = 8'h2C;
  localparam logic [7:0] OFS_VER  = 8'h5C;
  localparam logic [7:0] OFS_DATA = 8'h60;

  localparam logic [31:0] HOST_VERSION = 32'h0001_0200;

  typedef enum logic [1:0] {
    XM_DUPLEX  = 2'd0,
    XM_TX_ONLY = 2'd1,
    XM_RX_ONLY = 2'd2,
    XM_PROM    = 2'd3
  } xfer_mode_e;

  typedef struct packed {
    xfer_mode_e mode;
    logic       cpol;
    logic       cpha;
    logic [3:0] bits_m1;
  } host_cfg_t;

endpackage

// File: rtl/apb_spi_host_fifo.sv
module apb_spi_host_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  assign full    = (lvl_q == LW'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign do_push = push & ~full & ~clr;
  assign do_pop  = pop & ~empty & ~clr;
  assign rdata   = empty ? '0 : mem[rptr_q];
  assign level   = lvl_q;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    lvl_d  = lvl_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      lvl_d  = '0;
    end else begin
      if (do_push) wptr_d = wptr_q + 1'b1;
      if (do_pop)  rptr_d = rptr_q + 1'b1;
      lvl_d = lvl_q + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= wdata;
  end

endmodule

// File: rtl/apb_spi_host_regs.sv
module apb_spi_host_regs
  import apb_spi_host_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SLAVES = 4,
  parameter int DIVW   = 16,
  parameter int CNTW   = 16,
  parameter int WW     = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [7:0]        paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              en,
  output host_cfg_t         cfg,
  output logic [9:0]        ctrl_raw,
  output logic [SLAVES-1:0] ssel,
  output logic [DIVW-1:0]   div,
  output logic [CNTW-1:0]   frame_cnt,
  output logic [AW-1:0]     thr,
  output logic              tx_push,
  output logic [WW-1:0]     tx_wdata,
  output logic              rx_pop,
  output logic              ro_kick,
  input  logic [LW-1:0]     tx_lvl,
  input  logic [LW-1:0]     rx_lvl,
  input  logic [WW-1:0]     rx_rdata,
  input  logic              tx_full,
  input  logic              tx_empty,
  input  logic              rx_full,
  input  logic              rx_empty,
  input  logic              busy
);

  logic              wr_acc, rd_acc, cfg_we;
  logic [9:0]        ctrl_q, ctrl_d;
  logic [CNTW-1:0]   cnt_q, cnt_d;
  logic              en_q, en_d;
  logic [SLAVES-1:0] ssel_q, ssel_d;
  logic [DIVW-1:0]   div_q, div_d;
  logic [AW-1:0]     thr_q, thr_d;
  logic [7:0]        mask_q, mask_d;
  logic              data_hit;

  assign wr_acc   = psel & penable & pwrite;
  assign rd_acc   = psel & penable & ~pwrite;
  assign cfg_we   = wr_acc & ~en_q;
  assign data_hit = (paddr == OFS_DATA);

  assign cfg.mode    = xfer_mode_e'(ctrl_q[9:8]);
  assign cfg.cpol    = ctrl_q[7];
  assign cfg.cpha    = ctrl_q[6];
  assign cfg.bits_m1 = ctrl_q[3:0];

  assign ctrl_raw  = ctrl_q;
  assign en        = en_q;
  assign ssel      = ssel_q;
  assign div       = div_q;
  assign frame_cnt = cnt_q;
  assign thr       = thr_q;

  assign tx_wdata = pwdata[WW-1:0];
  assign tx_push  = wr_acc & data_hit & en_q & (cfg.mode != XM_RX_ONLY);
  assign ro_kick  = wr_acc & data_hit & en_q & (cfg.mode == XM_RX_ONLY);
  assign rx_pop   = rd_acc & data_hit;

  always_comb begin
    ctrl_d = ctrl_q;
    cnt_d  = cnt_q;
    en_d   = en_q;
    ssel_d = ssel_q;
    div_d  = div_q;
    thr_d  = thr_q;
    mask_d = mask_q;
    if (wr_acc && paddr == OFS_EN)   en_d   = pwdata[0];
    if (wr_acc && paddr == OFS_MASK) mask_d = pwdata[7:0];
    if (cfg_we) begin
      unique case (paddr)
        OFS_CTRL: ctrl_d = pwdata[9:0];
        OFS_CNT:  cnt_d  = pwdata[CNTW-1:0];
        OFS_SSEL: ssel_d = pwdata[SLAVES-1:0];
        OFS_DIV:  div_d  = {pwdata[DIVW-1:1], 1'b0};
        OFS_THR:  if (pwdata < 32'(DEPTH)) thr_d = pwdata[AW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 10'h007;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      ssel_q <= '0;
      div_q  <= DIVW'(2);
      thr_q  <= '0;
      mask_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
      en_q   <= en_d;
      ssel_q <= ssel_d;
      div_q  <= div_d;
      thr_q  <= thr_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    prdata = '0;
    unique case (paddr)
      OFS_CTRL: prdata = 32'(ctrl_q);
      OFS_CNT:  prdata = 32'(cnt_q);
      OFS_EN:   prdata = 32'(en_q);
      OFS_SSEL: prdata = 32'(ssel_q);
      OFS_DIV:  prdata = 32'(div_q);
      OFS_THR:  prdata = 32'(thr_q);
      OFS_TXL:  prdata = 32'(tx_lvl);
      OFS_RXL:  prdata = 32'(rx_lvl);
      OFS_STAT: prdata = {25'd0, 2'b00, rx_full, ~rx_empty, tx_empty, ~tx_full, busy};
      OFS_MASK: prdata = 32'(mask_q);
      OFS_VER:  prdata = HOST_VERSION;
      OFS_DATA: prdata = 32'(rx_rdata);
      default:  prdata = '0;
    endcase
  end

endmodule

// File: rtl/apb_spi_host_engine.sv
module apb_spi_host_engine
  import apb_spi_host_pkg::*;
#(
  parameter int SLAVES = 4,
  parameter int DIVW   = 16,
  parameter int CNTW   = 16,
  parameter int WW     = 16,
  localparam int BW    = $clog2(WW) + 1,
  localparam int EW    = BW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  host_cfg_t         cfg,
  input  logic [DIVW-1:0]   div,
  input  logic [CNTW-1:0]   frame_cnt,
  input  logic [SLAVES-1:0] ssel,
  input  logic              ro_kick,
  input  logic              tx_empty,
  input  logic [WW-1:0]     tx_rdata,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WW-1:0]     rx_wdata,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [SLAVES-1:0] ss_n
);

  typedef enum logic {EN_IDLE, EN_RUN} eng_state_e;

  eng_state_e      state_q, state_d;
  logic [DIVW-2:0] hcnt_q, hcnt_d, half, half_m1;
  logic [EW-1:0]   edge_q, edge_d, edges_tot;
  logic            phase_q, phase_d;
  logic            mosi_q, mosi_d;
  logic [WW-1:0]   tx_sr_q, tx_sr_d, rx_sr_q, rx_sr_d;
  logic [CNTW:0]   left_q, left_d;
  logic [BW-1:0]   nbits;
  logic [WW:0]     full_mask;
  logic            tick, lead, sample, load, ro_mode;
  logic [WW-1:0]   ld_word, ld_just;

  assign ro_mode   = (cfg.mode == XM_RX_ONLY);
  assign nbits     = BW'(cfg.bits_m1) + BW'(1);
  assign edges_tot = {1'b0, nbits} << 1;
  assign half      = div[DIVW-1:1];
  assign half_m1   = (half == '0) ? '0 : half - 1'b1;
  assign tick      = (hcnt_q == half_m1);
  assign lead      = ~edge_q[0];
  assign sample    = lead ^ cfg.cpha;
  assign full_mask = ({{WW{1'b0}}, 1'b1} << nbits) - 1'b1;
  assign ld_word   = ro_mode ? '1 : tx_rdata;
  assign ld_just   = ld_word << (BW'(WW) - nbits);

  assign busy     = (state_q == EN_RUN);
  assign sclk     = cfg.cpol ^ phase_q;
  assign mosi     = mosi_q;
  assign rx_wdata = rx_sr_q & full_mask[WW-1:0];
  assign ss_n     = busy ? ~ssel : '1;

  always_comb begin
    state_d = state_q;
    hcnt_d  = hcnt_q;
    edge_d  = edge_q;
    phase_d = phase_q;
    mosi_d  = mosi_q;
    tx_sr_d = tx_sr_q;
    rx_sr_d = rx_sr_q;
    left_d  = left_q;
    load    = 1'b0;
    tx_pop  = 1'b0;
    rx_push = 1'b0;

    unique case (state_q)
      EN_IDLE: begin
        phase_d = 1'b0;
        hcnt_d  = '0;
        if (ro_kick) begin
          left_d = {1'b0, frame_cnt} + 1'b1;
          load   = 1'b1;
        end else if (!ro_mode && !tx_empty) begin
          load = 1'b1;
        end
      end
      EN_RUN: begin
        if (!tick) begin
          hcnt_d = hcnt_q + 1'b1;
        end else begin
          hcnt_d = '0;
          if (edge_q == edges_tot) begin
            rx_push = (cfg.mode != XM_TX_ONLY);
            if (ro_mode ? (left_q > 1) : !tx_empty) begin
              load = 1'b1;
              if (ro_mode) left_d = left_q - 1'b1;
            end else begin
              state_d = EN_IDLE;
            end
          end else begin
            phase_d = ~phase_q;
            edge_d  = edge_q + 1'b1;
            if (sample) begin
              rx_sr_d = {rx_sr_q[WW-2:0], miso};
            end else begin
              mosi_d  = tx_sr_q[WW-1];
              tx_sr_d = tx_sr_q << 1;
            end
          end
        end
      end
      default: state_d = EN_IDLE;
    endcase

    if (load) begin
      state_d = EN_RUN;
      edge_d  = '0;
      hcnt_d  = '0;
      phase_d = 1'b0;
      tx_pop  = ~ro_mode;
      if (!cfg.cpha) begin
        mosi_d  = ld_just[WW-1];
        tx_sr_d = ld_just << 1;
      end else begin
        tx_sr_d = ld_just;
      end
    end

    if (!en) begin
      state_d = EN_IDLE;
      phase_d = 1'b0;
      left_d  = '0;
      tx_pop  = 1'b0;
      rx_push = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= EN_IDLE;
      hcnt_q  <= '0;
      edge_q  <= '0;
      phase_q <= 1'b0;
      mosi_q  <= 1'b0;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      hcnt_q  <= hcnt_d;
      edge_q  <= edge_d;
      phase_q <= phase_d;
      mosi_q  <= mosi_d;
      tx_sr_q <= tx_sr_d;
      rx_sr_q <= rx_sr_d;
      left_q  <= left_d;
    end
  end

endmodule

// File: rtl/apb_spi_host.sv
module apb_spi_host
  import apb_spi_host_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SLAVES = 4,
  parameter int DIVW   = 16,
  parameter int CNTW   = 16,
  parameter int WW     = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [7:0]        paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [SLAVES-1:0] ss_n
);

  host_cfg_t         cfg_w;
  logic [9:0]        ctrl_w;
  logic              en_w, busy_w;
  logic [SLAVES-1:0] ssel_w;
  logic [DIVW-1:0]   div_w;
  logic [CNTW-1:0]   cnt_w;
  logic [AW-1:0]     thr_w;
  logic              tx_push_w, tx_pop_w, rx_push_w, rx_pop_w, ro_kick_w;
  logic [WW-1:0]     tx_wdata_w, tx_rdata_w, rx_wdata_w, rx_rdata_w;
  logic [LW-1:0]     tx_lvl_w, rx_lvl_w;
  logic              tx_full_w, tx_empty_w, rx_full_w, rx_empty_w;

  apb_spi_host_regs #(
    .DEPTH(DEPTH), .SLAVES(SLAVES), .DIVW(DIVW), .CNTW(CNTW), .WW(WW)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata),
    .en(en_w), .cfg(cfg_w), .ctrl_raw(ctrl_w), .ssel(ssel_w), .div(div_w),
    .frame_cnt(cnt_w), .thr(thr_w),
    .tx_push(tx_push_w), .tx_wdata(tx_wdata_w), .rx_pop(rx_pop_w),
    .ro_kick(ro_kick_w),
    .tx_lvl(tx_lvl_w), .rx_lvl(rx_lvl_w), .rx_rdata(rx_rdata_w),
    .tx_full(tx_full_w), .tx_empty(tx_empty_w),
    .rx_full(rx_full_w), .rx_empty(rx_empty_w), .busy(busy_w)
  );

  apb_spi_host_fifo #(.W(WW), .DEPTH(DEPTH)) txq_i (
    .clk(clk), .rst_n(rst_n), .clr(~en_w),
    .push(tx_push_w), .wdata(tx_wdata_w),
    .pop(tx_pop_w), .rdata(tx_rdata_w),
    .level(tx_lvl_w), .full(tx_full_w), .empty(tx_empty_w)
  );

  apb_spi_host_fifo #(.W(WW), .DEPTH(DEPTH)) rxq_i (
    .clk(clk), .rst_n(rst_n), .clr(~en_w),
    .push(rx_push_w), .wdata(rx_wdata_w),
    .pop(rx_pop_w), .rdata(rx_rdata_w),
    .level(rx_lvl_w), .full(rx_full_w), .empty(rx_empty_w)
  );

  apb_spi_host_engine #(
    .SLAVES(SLAVES), .DIVW(DIVW), .CNTW(CNTW), .WW(WW)
  ) eng_i (
    .clk(clk), .rst_n(rst_n), .en(en_w), .cfg(cfg_w), .div(div_w),
    .frame_cnt(cnt_w), .ssel(ssel_w), .ro_kick(ro_kick_w),
    .tx_empty(tx_empty_w), .tx_rdata(tx_rdata_w), .tx_pop(tx_pop_w),
    .rx_push(rx_push_w), .rx_wdata(rx_wdata_w), .busy(busy_w),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

endmodule

// File: rtl/apb_spi_host_chk.sv
module apb_spi_host_chk #(
  parameter int DEPTH  = 8,
  parameter int SLAVES = 4,
  parameter int DIVW   = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              busy,
  input logic              sclk,
  input logic [9:0]        ctrl,
  input logic [DIVW-1:0]   div,
  input logic [SLAVES-1:0] ssel,
  input logic [SLAVES-1:0] ss_n,
  input logic [LW-1:0]     tx_lvl,
  input logic [LW-1:0]     rx_lvl
);

  a_r7_ss_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ss_n == '1));

  a_r7_ss_select: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ss_n == ~ssel));

  a_r5_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == ctrl[7]));

  a_r3_flush: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |=> (tx_lvl == '0) && (rx_lvl == '0) && !busy);

  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> ($stable(ctrl) && $stable(div) && $stable(ssel)));

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH)));

  a_r3_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

endmodule

bind apb_spi_host apb_spi_host_chk #(
  .DEPTH(DEPTH), .SLAVES(SLAVES), .DIVW(DIVW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en_w), .busy(busy_w), .sclk(sclk),
  .ctrl(ctrl_w), .div(div_w), .ssel(ssel_w), .ss_n(ss_n),
  .tx_lvl(tx_lvl_w), .rx_lvl(rx_lvl_w)
);

// File: tb/apb_spi_host_tb_top.sv
module apb_spi_host_tb_top;
  import apb_spi_host_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        sclk, mosi;
  logic        miso_r = 1'b0;
  logic [3:0]  ss_n;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  // behavioural target model state
  int  stx[$];
  int  got[$];
  int  s_bits = 8;
  bit  s_cpol = 0, s_cpha = 0;
  int  s_in = 0, s_ic = 0, s_out = 0, s_oi = 0;
  bit  ss_prev = 0, sclk_prev = 0;
  bit  mon_on = 0;
  int  mon_err = 0;
  logic [3:0] seen_ss = 4'hF;
  int  last_rise = -1, per = 0;
  logic ss_act;
  logic lead;

  assign ss_act = ~&ss_n;

  apb_spi_host dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .sclk(sclk), .mosi(mosi), .miso(miso_r), .ss_n(ss_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic int next_word();
    if (stx.size() > 0) return stx.pop_front();
    return 0;
  endfunction

  always @(sclk or ss_act) begin
    if (ss_act && !ss_prev) begin
      s_in = 0; s_ic = 0; s_oi = 0;
      if (!s_cpha) begin
        s_out = next_word();
        miso_r = 1'((s_out >> (s_bits - 1)) & 1);
      end
    end else if (ss_act && sclk != sclk_prev) begin
      lead = (sclk != s_cpol);
      if (lead ^ s_cpha) begin
        s_in = (s_in << 1) | int'(mosi);
        s_ic++;
        if (s_ic == s_bits) begin
          got.push_back(s_in & ((1 << s_bits) - 1));
          s_in = 0; s_ic = 0;
        end
      end else begin
        if (!s_cpha) begin
          s_oi++;
          if (s_oi == s_bits) begin s_out = next_word(); s_oi = 0; end
          miso_r = 1'((s_out >> (s_bits - 1 - s_oi)) & 1);
        end else begin
          if (s_oi == 0) s_out = next_word();
          miso_r = 1'((s_out >> (s_bits - 1 - s_oi)) & 1);
          s_oi++;
          if (s_oi == s_bits) s_oi = 0;
        end
      end
    end
    ss_prev = ss_act;
    sclk_prev = sclk;
  end

  always @(posedge sclk) if (ss_act) begin
    if (last_rise >= 0) per = cyc - last_rise;
    last_rise = cyc;
  end

  // per-clock reference comparison: idle clock level and select seen
  always @(negedge clk) if (mon_on) begin
    if (!ss_act && sclk !== s_cpol) mon_err++;
    if (ss_act) seen_ss = ss_n;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input int d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic wait_done(input string req);
    int s;
    for (int i = 0; i < 4000; i++) begin
      rd(OFS_STAT, s);
      if ((s & 5) == 4) return;
    end
    chk(req, s & 5, 4);
  endtask

  task automatic setup(input int ctrl, input int dv, input int sel, input int cnt);
    mon_on = 0;
    wr(OFS_EN, 0);
    wr(OFS_CTRL, ctrl);
    wr(OFS_DIV, dv);
    wr(OFS_SSEL, sel);
    wr(OFS_CNT, cnt);
    s_bits = (ctrl & 15) + 1;
    s_cpha = ctrl[6];
    s_cpol = ctrl[7];
    @(negedge clk);
    mon_on = 1;
    wr(OFS_EN, 1);
  endtask

  task automatic duplex(input string req, input int nw, input int seed);
    int msk, v;
    int txw[$];
    int exp_rx[$];
    msk = (1 << s_bits) - 1;
    got.delete(); stx.delete();
    for (int i = 0; i < nw; i++) begin
      txw.push_back((seed * 29 + i * 113 + 7) & msk);
      exp_rx.push_back((seed * 53 + i * 71 + 3) & msk);
      stx.push_back(exp_rx[i]);
    end
    for (int i = 0; i < nw; i++) wr(OFS_DATA, txw[i]);
    wait_done(req);
    chk(req, got.size(), nw);
    for (int i = 0; i < nw; i++) chk(req, (i < got.size()) ? got[i] : -1, txw[i]);
    rd(OFS_RXL, v); chk(req, v, nw);
    for (int i = 0; i < nw; i++) begin rd(OFS_DATA, v); chk(req, v, exp_rx[i]); end
  endtask

  task automatic finish_up();
    if (finished) return;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    mon_on = 1;

    // R1 reset state
    rd(OFS_CTRL, v); chk("R1", v, 32'h007);
    rd(OFS_DIV, v);  chk("R1", v, 2);
    rd(OFS_EN, v);   chk("R1", v, 0);
    rd(OFS_SSEL, v); chk("R1", v, 0);
    rd(OFS_STAT, v); chk("R1 R12", v, 32'h06);
    rd(OFS_TXL, v);  chk("R1", v, 0);
    rd(OFS_VER, v);  chk("R1 R12", v, 32'h0001_0200);
    chk("R1", int'(ss_n), 4'hF);
    chk("R1", int'(sclk), 0);

    // R11 threshold probing
    wr(OFS_THR, 5);   rd(OFS_THR, v); chk("R11", v, 5);
    wr(OFS_THR, 8);   rd(OFS_THR, v); chk("R11", v, 5);
    wr(OFS_THR, 200); rd(OFS_THR, v); chk("R11", v, 5);
    wr(OFS_THR, 7);   rd(OFS_THR, v); chk("R11", v, 7);

    // R4 R5 all four clock modes, 8-bit frames
    for (int m = 0; m < 4; m++) begin
      setup(32'h007 | (m << 6), 4, 1, 0);
      duplex("R5", 3, m + 1);
    end

    // R2 configuration writes ignored while enabled
    wr(OFS_CTRL, 32'h00F); rd(OFS_CTRL, v); chk("R2", v, 32'h0C7);
    wr(OFS_DIV, 40);       rd(OFS_DIV, v);  chk("R2", v, 4);
    wr(OFS_SSEL, 8);       rd(OFS_SSEL, v); chk("R2", v, 1);
    wr(OFS_THR, 2);        rd(OFS_THR, v);  chk("R2", v, 7);

    // R6 R7 R4 12-bit frames, cpol=1 cpha=1, odd divider
    setup(32'h0CB, 7, 4, 0);
    rd(OFS_DIV, v); chk("R6", v, 6);
    last_rise = -1; seen_ss = 4'hF;
    duplex("R4", 4, 9);
    chk("R6", per, 6);
    chk("R7", int'(seen_ss), 4'hB);
    chk("R7", int'(ss_n), 4'hF);

    // R8 transmit only
    setup(32'h107, 4, 2, 0);
    got.delete(); stx.delete();
    wr(OFS_DATA, 32'h3C); wr(OFS_DATA, 32'hA1); wr(OFS_DATA, 32'h5E);
    wait_done("R8");
    chk("R8", got.size(), 3);
    if (got.size() == 3) chk("R8", got[2], 32'h5E);
    rd(OFS_RXL, v); chk("R8", v, 0);

    // R10 R12 R3 overflow, status and flush
    setup(32'h007, 32, 1, 0);
    got.delete(); stx.delete();
    wr(OFS_DATA, 1); wr(OFS_DATA, 2);
    wait_done("R3");
    for (int i = 0; i < 10; i++) wr(OFS_DATA, 32'h40 + i);
    rd(OFS_TXL, v);  chk("R10", v, 8);
    rd(OFS_RXL, v);  chk("R10", v, 2);
    rd(OFS_STAT, v); chk("R12", v, 32'h09);
    mon_on = 0;
    wr(OFS_EN, 0);
    rd(OFS_TXL, v);  chk("R3", v, 0);
    rd(OFS_RXL, v);  chk("R3", v, 0);
    chk("R3", int'(ss_n), 4'hF);
    rd(OFS_STAT, v); chk("R3", v, 32'h06);
    rd(OFS_DATA, v); chk("R10", v, 0);

    // R9 receive only, count 2 gives 3 frames
    setup(32'h207, 4, 8, 2);
    got.delete(); stx.delete();
    stx.push_back(32'h11); stx.push_back(32'hC3); stx.push_back(32'h7D);
    wr(OFS_DATA, 32'h55);
    rd(OFS_TXL, v); chk("R9", v, 0);
    wait_done("R9");
    chk("R9", got.size(), 3);
    for (int i = 0; i < 3; i++) chk("R9", (i < got.size()) ? got[i] : -1, 32'hFF);
    rd(OFS_RXL, v); chk("R9", v, 3);
    rd(OFS_DATA, v); chk("R9", v, 32'h11);
    rd(OFS_DATA, v); chk("R9", v, 32'hC3);
    rd(OFS_DATA, v); chk("R9", v, 32'h7D);

    chk("R5 monitor", mon_err, 0);
    finish_up();
  end

endmodule